// File: doc/BRIEF.md
# SD Card SPI Reset Sequencer

This block is a small SPI master that brings an SD card out of its power-up state and into SPI mode. A single-cycle start pulse makes it pull chip select low, clock one byte to check that the card is ready, send the six-byte reset command frame, and then read bytes until the card answers. Every byte is full duplex. In each step either the transmitted byte or the received byte carries meaning, and the other is filler.

The first received byte whose top bit is clear is taken as the card's status and is shown on `resp`. A value of 0x01 means the card is idle, which is the normal answer to a reset. If no such byte arrives within a set number of poll bytes, the block flags an error instead. In both cases it releases chip select and clocks one more byte before it reports. The serial clock is the system clock divided down, and SPI mode 0 is used.

Top module: `sd_reset_seq`

## Requirements
- R1: After reset and while idle: `cs_n` is 1, `sclk` is 0, and `busy`, `done` and `error` are 0.
- R2: A `start` pulse while idle drives `cs_n` low and raises `busy`. A `start` pulse while `busy` is high has no effect on the byte sequence or on the number of completions.
- R3: SPI mode 0, most significant bit first. `sclk` idles low and has a period of 2*HALF_DIV system clocks. `mosi` changes only on falling `sclk` edges. `miso` is sampled on rising edges.
- R4: The first byte with `cs_n` low is a readiness byte. The block sends 0xFF, and the value it receives has no effect on the result.
- R5: The next six bytes sent are 0x40, 0x00, 0x00, 0x00, 0x00, 0x95, in that order. The bytes received during them are ignored, even if their top bit is clear.
- R6: After the frame, the block sends 0xFF poll bytes. The first received byte with bit 7 equal to 0 ends polling, and its value appears on `resp`.
- R7: If POLL_LIMIT poll bytes pass with bit 7 set in every one, the block ends with `error`. `resp` then holds the last polled byte.
- R8: After the last poll byte, `cs_n` goes high and exactly 8 more `sclk` rising edges follow. Then `done` (on success) or `error` (on timeout) is high for exactly one cycle, the same cycle in which `busy` falls. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to run the reset sequence |
| miso | input | 1 | Serial data from the card |
| sclk | output | 1 | Serial clock to the card |
| mosi | output | 1 | Serial data to the card |
| cs_n | output | 1 | Active-low card select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a status byte was received |
| error | output | 1 | One-cycle pulse when polling timed out |
| resp | output | 8 | Status byte received (last polled byte on timeout) |

## Verification
The card model is fed several answer patterns:
- a late 0x01, behind readiness and frame bytes that have a clear top bit, which shows that those steps are ignored;
- another status value on the first poll byte, which shows that any byte with a clear top bit counts;
- a status on the very last allowed poll byte, against a stream with no status at all, which separates the success and timeout boundary.

In every pattern the bench compares the bytes sent on `mosi` with the fixed frame and counts the clock edges after chip select is released. A second start issued mid-run shows whether a busy request can disturb the sequence.

// File: rtl/sd_reset_seq.sv
module sd_reset_seq #(
  parameter int HALF_DIV   = 2,
  parameter int POLL_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [7:0] resp
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_READY, S_CMD, S_POLL, S_TAIL} st_t;

  st_t           st;
  logic [CW-1:0] div;
  logic [2:0]    bitn, idx;
  logic [PW-1:0] pcnt;
  logic [7:0]    tx, rx;
  logic          ok;

  function automatic logic [7:0] frame(input logic [2:0] i);
    case (i)
      3'd0:    frame = 8'h40;
      3'd5:    frame = 8'h95;
      default: frame = 8'h00;
    endcase
  endfunction

  wire tick = (div == CW'(HALF_DIV - 1));

  assign busy = (st != S_IDLE);
  assign mosi = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; bitn <= '0; idx <= '0; pcnt <= '0;
      tx <= 8'hFF; rx <= 8'hFF; ok <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1;
      done <= 1'b0; error <= 1'b0; resp <= 8'h00;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st <= S_READY; cs_n <= 1'b0; tx <= 8'hFF;
          bitn <= '0; div <= '0; sclk <= 1'b0;
        end
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn != 3'd7) begin
              bitn <= bitn + 1'b1;
              tx   <= {tx[6:0], 1'b1};
            end else begin
              bitn <= '0;
              case (st)
                S_READY: begin
                  st <= S_CMD; idx <= '0; tx <= frame(3'd0);
                end
                S_CMD: begin
                  if (idx == 3'd5) begin
                    st <= S_POLL; pcnt <= '0; tx <= 8'hFF;
                  end else begin
                    idx <= idx + 1'b1; tx <= frame(idx + 1'b1);
                  end
                end
                S_POLL: begin
                  tx   <= 8'hFF;
                  resp <= rx;
                  if (!rx[7]) begin
                    ok <= 1'b1; st <= S_TAIL; cs_n <= 1'b1;
                  end else if (pcnt == PW'(POLL_LIMIT - 1)) begin
                    ok <= 1'b0; st <= S_TAIL; cs_n <= 1'b1;
                  end else begin
                    pcnt <= pcnt + 1'b1;
                  end
                end
                default: begin
                  st <= S_IDLE; tx <= 8'hFF;
                  done <= ok; error <= ~ok;
                end
              endcase
            end
          end
        end
      end
    end
  end
endmodule

module sd_reset_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done,
  input logic error
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> !(done || error));
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!busy && $past(busy)));
endmodule

bind sd_reset_seq sd_reset_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .busy(busy), .done(done), .error(error)
);

// File: tb/tb_sd_reset_seq.sv
module tb_sd_reset_seq;
  localparam int HALF_DIV = 2;
  localparam int POLL_LIMIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic miso;
  logic sclk, mosi, cs_n, busy, done, error;
  logic [7:0] resp;

  always #10 clk = ~clk;

  sd_reset_seq #(.HALF_DIV(HALF_DIV), .POLL_LIMIT(POLL_LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done), .error(error),
    .resp(resp)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // card model: stream of bytes sent by the card, byte 0 = readiness byte
  logic [7:0] stream [16];
  int   bitpos;
  logic miso_r = 1'b1;
  assign miso = cs_n ? 1'b1 : miso_r;

  always @(negedge cs_n) begin
    bitpos = 0;
    miso_r = stream[0][7];
  end
  always @(negedge sclk) if (!cs_n) begin
    bitpos++;
    miso_r = (bitpos < 128) ? stream[bitpos / 8][7 - (bitpos % 8)] : 1'b1;
  end

  // capture of bytes sent by the block
  logic [7:0] cap = '0;
  int ncap = 0;
  int tail_rises = 0;
  logic [7:0] got [$];
  time rise_t [$];

  always @(posedge sclk) begin
    rise_t.push_back($time);
    if (!cs_n) begin
      cap = {cap[6:0], mosi};
      ncap++;
      if (ncap % 8 == 0) got.push_back(cap);
    end else begin
      tail_rises++;
    end
  end

  // per-clock reference of idle behaviour and pulse widths
  int idle_bad = 0;
  int ends = 0;
  int both_bad = 0;
  logic prev_end = 1'b0;
  int wide_bad = 0;
  always @(negedge clk) if (rst_n) begin
    if (!busy && (!cs_n || sclk)) idle_bad++;
    if (done && error) both_bad++;
    if ((done || error) && prev_end) wide_bad++;
    if (done || error) ends++;
    prev_end = done || error;
  end

  int total_cycles = 0;
  always @(posedge clk) total_cycles++;

  task automatic run(input string name, input logic [7:0] rdy, input logic [7:0] fill,
                     input logic [7:0] polls [8], input bit restart);
    int npoll;
    logic [7:0] eresp;
    bit eok;
    int wd;
    int ends0;
    logic [7:0] expb;
    stream[0] = rdy;
    for (int i = 1; i < 7; i++) stream[i] = fill;
    for (int i = 0; i < 8; i++) stream[7 + i] = polls[i];
    stream[15] = 8'hFF;
    // expected outcome
    eok = 1'b0; npoll = POLL_LIMIT; eresp = polls[POLL_LIMIT - 1];
    for (int i = 0; i < POLL_LIMIT; i++)
      if (!eok && !polls[i][7]) begin eok = 1'b1; npoll = i + 1; eresp = polls[i]; end
    got.delete(); ncap = 0; tail_rises = 0; rise_t.delete();
    ends0 = ends;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({"R2 cs low on start ", name}, cs_n, 1'b0);
    chk({"R2 busy on start ", name}, busy, 1'b1);
    if (restart) begin
      repeat (100) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wd = 0;
    while (!(done || error) && wd < 5000) begin @(negedge clk); wd++; end
    if (wd >= 5000) begin
      errors++; checks++;
      $display("FAIL R8 watchdog %s: actual timeout expected completion", name);
      return;
    end
    chk({"R8 done flag ", name}, done, eok);
    chk({"R7 error flag ", name}, error, !eok);
    chk({"R8 busy low at end ", name}, busy, 1'b0);
    chk({"R6 resp ", name}, resp, eresp);
    chk({"R8 tail edges ", name}, tail_rises, 8);
    chk({"R6 byte count ", name}, got.size(), 7 + npoll);
    for (int i = 0; i < got.size(); i++) begin
      case (i)
        1: expb = 8'h40;
        6: expb = 8'h95;
        2, 3, 4, 5: expb = 8'h00;
        default: expb = 8'hFF;
      endcase
      chk($sformatf("%s byte %0d %s", (i == 0) ? "R4" : (i < 7) ? "R5" : "R6", i, name),
          got[i], expb);
    end
    @(negedge clk);
    chk({"R8 single pulse ", name}, done | error, 1'b0);
    chk({"R2 one completion ", name}, ends - ends0, 1);
    if (rise_t.size() >= 2)
      chk({"R3 sclk period ", name}, rise_t[1] - rise_t[0], 2 * HALF_DIV * 20);
    repeat (20) @(negedge clk);
    chk({"R2 no rerun ", name}, busy, 1'b0);
  endtask

  initial begin
    logic [7:0] p [8];
    repeat (3) @(negedge clk);
    chk("R1 cs_n reset", cs_n, 1'b1);
    chk("R1 sclk reset", sclk, 1'b0);
    chk("R1 busy reset", busy, 1'b0);
    chk("R1 done reset", done, 1'b0);
    chk("R1 error reset", error, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {cs_n, sclk, busy, done, error}, 5'b10000);

    p = '{8'hFF, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run("late idle status", 8'h00, 8'h00, p, 1'b0);
    p = '{8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run("first poll status", 8'hFF, 8'hFF, p, 1'b0);
    p = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h01};
    run("last poll status", 8'hFF, 8'h7F, p, 1'b0);
    p = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run("timeout", 8'hFF, 8'hFF, p, 1'b0);
    p = '{8'hFF, 8'hFF, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run("start while busy", 8'hFF, 8'hFF, p, 1'b1);

    chk("R1 idle lines every cycle", idle_bad, 0);
    chk("R8 never both flags", both_bad, 0);
    chk("R8 no wide pulse", wide_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL R8 global watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule